// File: doc/BRIEF.md
# Flash/Torch Event Sequencer

This block is the digital controller of a flash LED driver. It decides when the LED current source is on and which current step it delivers, in either the high-current flash range or the low-current torch range. An event is started either by a software-written enable bit or, in strobe mode, by a rising edge on an external strobe pin while that bit is set. Once started, the current climbs one step per ramp tick up to the programmed target. A flash event is bounded by a programmable timeout counted in millisecond ticks.

During a flash, a transmit-interrupt input can temporarily lower the output to the torch target. An input-voltage monitor can either blank the LED or fall back to a torch-range current. If the monitor trips part way up the ramp, the fallback torch level is reduced by the same fraction of the flash target reached so far. Overvoltage and short faults stop the event, clear the enable bit and lock the block out until the flags are read. Current-limit events only raise a flag. All comparator results arrive as digital inputs. The boost converter and the current source itself are outside the block.

Top module: `flt_seq_top`

## Requirements
- R1: `led_level` is a step count, 0 meaning off. In the flash range step n is n×100 mA (`led_flash`=1); in the torch range it is n×25 mA (`led_flash`=0). A 4-bit current code c selects target step c+1, and code 15 saturates to step 15.
- R2: An event first drives step 1 in the cycle after it starts. Each `step_tick` then raises the step by exactly one until the target is reached, where it holds.
- R3: With `strobe_mode`=0, a set enable bit (`en_wr` with `en_wdata`=1) starts an event of the kind chosen by `flash_sel` (1 = flash) on the next clock. Writing the bit back to 0 ends the event.
- R4: With `strobe_mode`=1, an event starts only on a low-to-high change of `strobe_pin` while the enable bit is set. A pin that is already high does not start one. The event ends as soon as the pin is low.
- R5: A flash ends after `tmo_code`+1 `ms_tick` pulses counted from the start of the event. `tmo_flag` then pulses for one cycle, together with the LED turning off.
- R6: A flash that ends because the strobe pin goes low before the timeout does not raise `tmo_flag`.
- R7: The end of every flash event clears the enable bit, so no further event starts until the bit is written again.
- R8: A torch event ignores both `ms_tick` and the transmit input.
- R9: During a flash, while `tx_en` and `tx_pin` are both high, the output shows the torch target with `led_flash`=0. When `tx_pin` falls, the flash step returns.
- R10: A monitor trip (`vmon_trip`) during a flash pulses `vmon_flag`. With `vmon_off_mode`=1 the LED turns off for the rest of the event. With `vmon_off_mode`=0 and the ramp complete, it shows the torch target. No new event starts until `flags_read`.
- R11: A monitor trip with `vmon_off_mode`=0 while the ramp is below the flash target shows floor(torch_target × reached_step / flash_target) in the torch range, and never less than 1.
- R12: The third `ovp_rise` pulse of an event, or `short_det` high during an event, ends it. It clears the enable bit and pulses `ovp_flag` or `short_flag`, and it blocks new events until a `flags_read` pulse.
- R13: An `ilim_evt` pulse during an event pulses `ilim_flag` and changes neither the LED output nor the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| flash_sel | input | 1 | 1 = flash event, 0 = torch event |
| strobe_mode | input | 1 | 1 = strobe pin controls the event |
| strobe_pin | input | 1 | External strobe |
| tx_en | input | 1 | Enables the transmit-interrupt input |
| tx_pin | input | 1 | Transmit interrupt |
| vmon_trip | input | 1 | Input-voltage monitor comparator result |
| vmon_off_mode | input | 1 | 1 = trip turns LED off, 0 = torch fallback |
| flash_code | input | 4 | Flash current code |
| torch_code | input | 4 | Torch current code |
| tmo_code | input | 5 | Flash timeout code, (code+1) ms |
| step_tick | input | 1 | Ramp advance tick |
| ms_tick | input | 1 | 1 ms timebase tick |
| ovp_rise | input | 1 | One pulse per rising overvoltage event |
| short_det | input | 1 | LED or output short comparator |
| ilim_evt | input | 1 | Inductor current-limit event |
| flags_read | input | 1 | Flag register read, releases the lockout |
| led_level | output | 4 | Current step, 0 = off |
| led_flash | output | 1 | 1 = flash range, 0 = torch range |
| led_on | output | 1 | Current source enabled |
| en_bit | output | 1 | Enable bit state |
| tmo_flag | output | 1 | Timeout flag pulse |
| ovp_flag | output | 1 | Overvoltage fault pulse |
| short_flag | output | 1 | Short fault pulse |
| ilim_flag | output | 1 | Current-limit pulse |
| vmon_flag | output | 1 | Monitor trip pulse |

## Verification
The bench first holds the strobe high before arming, so that a level-triggered start would be caught lighting the LED early. It then releases the strobe mid-flash, where a design that always flags at the end would raise the timeout flag wrongly. It counts exact millisecond ticks to the timeout: an off-by-one counter ends the flash one tick early or late. It saturates the flash code to check that the ramp climbs through every step to 15 and stops there. The monitor is tripped partway up the ramp, where a design that forgot the scaling would jump to the full torch target. It also checks that two overvoltage pulses are tolerated but the third is not, and that the fault lockout holds back a re-armed enable until the flags are read.

// File: rtl/flt_seq_pkg.sv
package flt_seq_pkg;
    parameter int LVL_W = 4;   // current step width
    parameter int TMO_W = 5;   // timeout code width
    parameter int OVP_N = 3;   // overvoltage rising events that end an event

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ON    = 2'd1,
        ST_VFALL = 2'd2,
        ST_VOFF  = 2'd3
    } seq_st_e;

    typedef struct packed {
        logic             on;
        logic             flash;
        logic [LVL_W-1:0] lvl;
    } led_drv_t;

    // code c selects step c+1, all-ones code saturates at the top step
    function automatic logic [LVL_W-1:0] code_to_step(input logic [LVL_W-1:0] c);
        if (c == {LVL_W{1'b1}}) return c;
        return c + 1'b1;
    endfunction

    // torch step scaled by reached/target, floored, at least one
    function automatic logic [LVL_W-1:0] scale_step(input logic [LVL_W-1:0] t,
                                                    input logic [LVL_W-1:0] r,
                                                    input logic [LVL_W-1:0] f);
        logic [2*LVL_W-1:0] p;
        p = ((2*LVL_W)'(t) * (2*LVL_W)'(r)) / (2*LVL_W)'(f);
        if (p == '0) return LVL_W'(1);
        return p[LVL_W-1:0];
    endfunction
endpackage

// File: rtl/flt_ramp.sv
module flt_ramp
    import flt_seq_pkg::*;
#(
    parameter int W = LVL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         adv,
    input  logic [W-1:0] tgt,
    output logic [W-1:0] lvl
);
    always_ff @(posedge clk) begin
        if (rst)                      lvl <= '0;
        else if (load)                lvl <= W'(1);
        else if (lvl > tgt)           lvl <= tgt;
        else if (adv && (lvl < tgt))  lvl <= lvl + 1'b1;
    end

    p_single_step_r2: assert property (@(posedge clk) disable iff (rst)
        !load |=> ((W+1)'(lvl) <= (W+1)'($past(lvl)) + 1'b1));
endmodule

// File: rtl/flt_timer.sv
module flt_timer
    import flt_seq_pkg::*;
#(
    parameter int W = TMO_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] code,
    output logic         expire
);
    logic [W-1:0] cnt;

    assign expire = run && tick && (cnt >= code);

    always_ff @(posedge clk) begin
        if (rst || clr || expire) cnt <= '0;
        else if (run && tick)     cnt <= cnt + 1'b1;
    end

    p_restart_after_expire_r5: assert property (@(posedge clk) disable iff (rst)
        expire |=> (cnt == '0));
endmodule

// File: rtl/flt_fault.sv
module flt_fault
    import flt_seq_pkg::*;
#(
    parameter int N = OVP_N
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic restart,
    input  logic ovp_rise,
    input  logic short_det,
    input  logic vm_hit,
    input  logic flags_read,
    output logic ovp_trip,
    output logic short_trip,
    output logic lock
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    logic [CW-1:0] cnt;

    assign ovp_trip   = active && ovp_rise && (cnt == CW'(N - 1));
    assign short_trip = active && short_det;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            lock <= 1'b0;
        end else begin
            if (restart)                           cnt <= '0;
            else if (active && ovp_rise && !ovp_trip) cnt <= cnt + 1'b1;
            if (ovp_trip || short_trip || vm_hit)  lock <= 1'b1;
            else if (flags_read)                   lock <= 1'b0;
        end
    end

    p_ovp_count_bound_r12: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) < N);
endmodule

// File: rtl/flt_seq_top.sv
module flt_seq_top
    import flt_seq_pkg::*;
#(
    parameter int LW = LVL_W,
    parameter int TW = TMO_W,
    parameter int ON = OVP_N
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_wr,
    input  logic          en_wdata,
    input  logic          flash_sel,
    input  logic          strobe_mode,
    input  logic          strobe_pin,
    input  logic          tx_en,
    input  logic          tx_pin,
    input  logic          vmon_trip,
    input  logic          vmon_off_mode,
    input  logic [LW-1:0] flash_code,
    input  logic [LW-1:0] torch_code,
    input  logic [TW-1:0] tmo_code,
    input  logic          step_tick,
    input  logic          ms_tick,
    input  logic          ovp_rise,
    input  logic          short_det,
    input  logic          ilim_evt,
    input  logic          flags_read,
    output logic [LW-1:0] led_level,
    output logic          led_flash,
    output logic          led_on,
    output logic          en_bit,
    output logic          tmo_flag,
    output logic          ovp_flag,
    output logic          short_flag,
    output logic          ilim_flag,
    output logic          vmon_flag
);
    seq_st_e       st;
    logic          evt_flash;
    logic          strobe_q;
    logic [LW-1:0] fb_lvl;
    logic [LW-1:0] ramp_lvl;
    logic [LW-1:0] ftgt, ttgt, rtgt;
    logic          active, start, released, expire, vm_hit;
    logic          ovp_trip, short_trip, lock;
    led_drv_t      drv;

    assign ftgt     = code_to_step(flash_code);
    assign ttgt     = code_to_step(torch_code);
    assign rtgt     = evt_flash ? ftgt : ttgt;
    assign active   = (st != ST_IDLE);
    assign start    = (st == ST_IDLE) && en_bit && !lock &&
                      (strobe_mode ? (strobe_pin && !strobe_q) : 1'b1);
    assign released = strobe_mode ? !strobe_pin : !en_bit;
    assign vm_hit   = (st == ST_ON) && evt_flash && vmon_trip;

    flt_ramp #(.W(LW)) u_ramp (
        .clk (clk), .rst (rst), .load (start),
        .adv (step_tick && (st == ST_ON)), .tgt (rtgt), .lvl (ramp_lvl)
    );

    flt_timer #(.W(TW)) u_timer (
        .clk (clk), .rst (rst), .clr (start),
        .run (active && evt_flash), .tick (ms_tick), .code (tmo_code),
        .expire (expire)
    );

    flt_fault #(.N(ON)) u_fault (
        .clk (clk), .rst (rst), .active (active), .restart (start),
        .ovp_rise (ovp_rise), .short_det (short_det), .vm_hit (vm_hit),
        .flags_read (flags_read), .ovp_trip (ovp_trip),
        .short_trip (short_trip), .lock (lock)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            evt_flash  <= 1'b0;
            strobe_q   <= 1'b0;
            fb_lvl     <= '0;
            en_bit     <= 1'b0;
            tmo_flag   <= 1'b0;
            ovp_flag   <= 1'b0;
            short_flag <= 1'b0;
            ilim_flag  <= 1'b0;
            vmon_flag  <= 1'b0;
        end else begin
            strobe_q   <= strobe_pin;
            tmo_flag   <= 1'b0;
            ovp_flag   <= ovp_trip;
            short_flag <= short_trip;
            ilim_flag  <= active && ilim_evt;
            vmon_flag  <= vm_hit;
            if (en_wr) en_bit <= en_wdata;
            if (st == ST_IDLE) begin
                if (start) begin
                    st        <= ST_ON;
                    evt_flash <= flash_sel;
                end
            end else if (ovp_trip || short_trip) begin
                st     <= ST_IDLE;
                en_bit <= 1'b0;
            end else if (expire) begin
                st       <= ST_IDLE;
                en_bit   <= 1'b0;
                tmo_flag <= 1'b1;
            end else if (released) begin
                st <= ST_IDLE;
                if (evt_flash) en_bit <= 1'b0;
            end else if (vm_hit) begin
                if (vmon_off_mode) begin
                    st <= ST_VOFF;
                end else begin
                    st     <= ST_VFALL;
                    fb_lvl <= (ramp_lvl < ftgt) ? scale_step(ttgt, ramp_lvl, ftgt) : ttgt;
                end
            end
        end
    end

    always_comb begin
        drv = '{on: 1'b0, flash: 1'b0, lvl: '0};
        case (st)
            ST_ON: begin
                drv.on = 1'b1;
                if (evt_flash && tx_en && tx_pin) begin
                    drv.lvl = ttgt;
                end else begin
                    drv.lvl   = ramp_lvl;
                    drv.flash = evt_flash;
                end
            end
            ST_VFALL: begin
                drv.on  = 1'b1;
                drv.lvl = fb_lvl;
            end
            default: ;
        endcase
    end

    assign led_on    = drv.on;
    assign led_flash = drv.flash;
    assign led_level = drv.lvl;

    p_timeout_dark_r5: assert property (@(posedge clk) disable iff (rst)
        tmo_flag |-> (!led_on && !en_bit));

    p_fault_clears_en_r12: assert property (@(posedge clk) disable iff (rst)
        (ovp_flag || short_flag) |-> (!en_bit && !led_on));

    p_strobe_edge_start_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_IDLE && st != ST_IDLE && $past(strobe_mode))
            |-> ($past(strobe_pin, 2) == 1'b0));

    p_ilim_no_stop_r13: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ON && ilim_evt && !ovp_trip && !short_trip && !expire &&
         !released && !vm_hit) |=> (st == ST_ON));
endmodule

// File: tb/flt_seq_top_bench.sv
`timescale 1ns/1ps
module flt_seq_top_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_wr = 0, en_wdata = 0, flash_sel = 0, strobe_mode = 0, strobe_pin = 0;
    logic tx_en = 0, tx_pin = 0, vmon_trip = 0, vmon_off_mode = 0;
    logic [3:0] flash_code = 0, torch_code = 0;
    logic [4:0] tmo_code = 0;
    logic step_tick = 0, ms_tick = 0, ovp_rise = 0, short_det = 0, ilim_evt = 0, flags_read = 0;
    logic [3:0] led_level;
    logic led_flash, led_on, en_bit, tmo_flag, ovp_flag, short_flag, ilim_flag, vmon_flag;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    flt_seq_top u_flt_seq_top (
        .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata), .flash_sel(flash_sel),
        .strobe_mode(strobe_mode), .strobe_pin(strobe_pin), .tx_en(tx_en), .tx_pin(tx_pin),
        .vmon_trip(vmon_trip), .vmon_off_mode(vmon_off_mode), .flash_code(flash_code),
        .torch_code(torch_code), .tmo_code(tmo_code), .step_tick(step_tick),
        .ms_tick(ms_tick), .ovp_rise(ovp_rise), .short_det(short_det), .ilim_evt(ilim_evt),
        .flags_read(flags_read), .led_level(led_level), .led_flash(led_flash),
        .led_on(led_on), .en_bit(en_bit), .tmo_flag(tmo_flag), .ovp_flag(ovp_flag),
        .short_flag(short_flag), .ilim_flag(ilim_flag), .vmon_flag(vmon_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr_en(input logic v);
        en_wr = 1; en_wdata = v; cyc(); en_wr = 0;
    endtask

    task automatic step();
        step_tick = 1; cyc(); step_tick = 0;
    endtask

    task automatic msk();
        ms_tick = 1; cyc(); ms_tick = 0;
    endtask

    task automatic ovp_pulse();
        ovp_rise = 1; cyc(); ovp_rise = 0;
    endtask

    task automatic rd_flags();
        flags_read = 1; cyc(); flags_read = 0; cyc();
    endtask

    task automatic t_reset();
        chk("R1", "reset led_on", led_on, 0);
        chk("R1", "reset level", led_level, 0);
        chk("R7", "reset en_bit", en_bit, 0);
    endtask

    task automatic t_torch();
        strobe_mode = 0; flash_sel = 0; torch_code = 2; tmo_code = 0;
        wr_en(1); cyc();
        chk("R3", "torch on", led_on, 1);
        chk("R2", "first step", led_level, 1);
        chk("R1", "torch range", led_flash, 0);
        step(); chk("R2", "step 2", led_level, 2);
        step(); chk("R2", "step 3", led_level, 3);
        step(); chk("R2", "hold at target", led_level, 3);
        for (int i = 0; i < 40; i++) msk();
        chk("R8", "torch ignores timeout", led_on, 1);
        tx_en = 1; tx_pin = 1; cyc();
        chk("R8", "torch ignores tx", led_level, 3);
        tx_en = 0; tx_pin = 0;
        wr_en(0); cyc();
        chk("R3", "write 0 ends", led_on, 0);
    endtask

    task automatic t_flash_timeout();
        flash_sel = 1; flash_code = 15; tmo_code = 2;
        wr_en(1); cyc();
        chk("R1", "flash range", led_flash, 1);
        for (int i = 0; i < 14; i++) step();
        chk("R1", "saturated code", led_level, 15);
        step(); chk("R2", "no step past target", led_level, 15);
        msk(); msk();
        chk("R5", "on before last tick", led_on, 1);
        msk();
        chk("R5", "off at timeout", led_on, 0);
        chk("R5", "timeout flag", tmo_flag, 1);
        chk("R7", "en cleared", en_bit, 0);
        cyc(); cyc();
        chk("R7", "no restart", led_on, 0);
    endtask

    task automatic t_tx();
        flash_code = 5; torch_code = 3; tmo_code = 31; tx_en = 1;
        wr_en(1); cyc();
        for (int i = 0; i < 5; i++) step();
        chk("R9", "flash step", led_level, 6);
        tx_pin = 1; #1;
        chk("R9", "tx torch level", led_level, 4);
        chk("R9", "tx torch range", led_flash, 0);
        cyc(); tx_pin = 0; #1;
        chk("R9", "tx release level", led_level, 6);
        chk("R9", "tx release range", led_flash, 1);
        tx_en = 0;
        wr_en(0); cyc();
        chk("R3", "flash stopped", led_on, 0);
        chk("R5", "no flag on write stop", tmo_flag, 0);
    endtask

    task automatic t_strobe();
        strobe_mode = 1; flash_sel = 1; tmo_code = 31;
        strobe_pin = 1;
        wr_en(1); cyc(); cyc(); cyc();
        chk("R4", "high level no start", led_on, 0);
        strobe_pin = 0; cyc();
        strobe_pin = 1; cyc();
        chk("R4", "edge starts", led_on, 1);
        msk(); msk();
        strobe_pin = 0; cyc();
        chk("R4", "low ends", led_on, 0);
        chk("R6", "no timeout flag", tmo_flag, 0);
        chk("R7", "en cleared after strobe flash", en_bit, 0);
        strobe_mode = 0;
    endtask

    task automatic t_vmon();
        flash_sel = 1; flash_code = 3; torch_code = 1; tmo_code = 0; vmon_off_mode = 1;
        wr_en(1); cyc();
        step(); step(); step();
        chk("R2", "ramp to 4", led_level, 4);
        vmon_trip = 1; cyc(); vmon_trip = 0;
        chk("R10", "off mode dark", led_on, 0);
        chk("R10", "vmon flag", vmon_flag, 1);
        msk();
        chk("R10", "event ended", en_bit, 0);
        wr_en(1); cyc();
        chk("R10", "locked", led_on, 0);
        rd_flags();
        chk("R10", "restart after read", led_on, 1);
        msk();
        vmon_off_mode = 0; wr_en(1); cyc();
        step(); step(); step();
        vmon_trip = 1; cyc(); vmon_trip = 0;
        chk("R10", "torch fallback level", led_level, 2);
        chk("R10", "torch fallback range", led_flash, 0);
        msk(); rd_flags();
    endtask

    task automatic t_vmon_ramp();
        flash_code = 9; torch_code = 3; tmo_code = 0; vmon_off_mode = 0;
        wr_en(1); cyc();
        for (int i = 0; i < 6; i++) step();
        chk("R2", "mid ramp", led_level, 7);
        vmon_trip = 1; cyc(); vmon_trip = 0;
        chk("R11", "scaled level", led_level, 2);
        msk(); rd_flags();
        torch_code = 0;
        wr_en(1); cyc();
        vmon_trip = 1; cyc(); vmon_trip = 0;
        chk("R11", "scaled floor one", led_level, 1);
        msk(); rd_flags();
    endtask

    task automatic t_faults();
        flash_code = 4; tmo_code = 31;
        wr_en(1); cyc();
        ovp_pulse(); ovp_pulse();
        chk("R12", "two ovp tolerated", led_on, 1);
        ovp_pulse();
        chk("R12", "third ovp off", led_on, 0);
        chk("R12", "ovp flag", ovp_flag, 1);
        chk("R12", "ovp clears en", en_bit, 0);
        wr_en(1); cyc();
        chk("R12", "locked after ovp", led_on, 0);
        rd_flags();
        chk("R12", "restart after read", led_on, 1);
        short_det = 1; cyc(); short_det = 0;
        chk("R12", "short off", led_on, 0);
        chk("R12", "short flag", short_flag, 1);
        chk("R12", "short clears en", en_bit, 0);
        rd_flags();
    endtask

    task automatic t_ilim();
        flash_sel = 0; torch_code = 5;
        wr_en(1); cyc();
        ilim_evt = 1; cyc(); ilim_evt = 0;
        chk("R13", "ilim flag", ilim_flag, 1);
        chk("R13", "still on", led_on, 1);
        chk("R13", "level kept", led_level, 1);
        chk("R13", "en kept", en_bit, 1);
        wr_en(0); cyc();
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        cyc(); cyc(); cyc();
        rst = 0;
        cyc();
        t_reset();
        t_torch();
        t_flash_timeout();
        t_tx();
        t_strobe();
        t_vmon();
        t_vmon_ramp();
        t_faults();
        t_ilim();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule